// File: doc/BRIEF.md
# Bit-Manipulation Instruction Execution Unit

This block carries out the single-bit and bit-mask memory instructions of an 8-bit processor core. The fetch logic supplies the opcode, the two bytes that follow it, the address of the opcode and the accumulator value, all with a one-cycle start pulse. The unit then runs the instruction over a fixed number of cycles. It makes at most one access per cycle on a single-port memory bus. When the cycle count ends it pulses a done strobe, along with the zero-flag update or the branch decision that the instruction produces.

The unit handles six operations. Two clear or set one bit of a zero-page byte. Two branch on the state of one bit of a zero-page byte. Two test the accumulator against a zero-page or absolute byte, then write back that byte with the accumulator's bits cleared or set. For the single-bit forms, the bit number comes from opcode bits [6:4]. The start cycle counts as cycle 1 of the instruction. Any opcode outside these encodings is flagged in the start cycle and has no other effect.

Top module: `bitop_exec_unit`

## Requirements
- R1: Opcodes with low nibble 7 and bit 7 = 0 (07, 17 … 77) read the zero-page byte at address {00, op_lo} and write it back with bit opcode[6:4] cleared and every other bit unchanged.
- R2: Opcodes with low nibble 7 and bit 7 = 1 (87 … F7) read the zero-page byte at {00, op_lo} and write it back with bit opcode[6:4] set and every other bit unchanged.
- R3: Opcodes with low nibble F read the zero-page byte at {00, op_lo} and never write. In the done cycle, br_taken is 1 only when bit opcode[6:4] of that byte equals opcode bit 7 (0F … 7F branch when the bit is clear, 8F … FF when it is set). br_target is pc + 3 + the sign-extended op_hi, modulo 2^16.
- R4: Opcode 04 (zero page) and opcode 0C (absolute) write back memory OR accumulator. Opcode 14 (zero page) and opcode 1C (absolute) write back memory AND NOT accumulator.
- R5: For 04/0C/14/1C, z_we is 1 in the done cycle and z_val is 1 exactly when (accumulator AND the byte read before the write) is zero. For every other operation, z_we stays 0. z_we and br_taken are never 1 outside a done cycle.
- R6: The start cycle is cycle 1. Zero-page forms read in cycle 3 and end in cycle 5. The absolute forms 0C/1C read in cycle 4 and end in cycle 6. A write, when there is one, happens in the final cycle, together with done. After reset every strobe is 0.
- R7: mem_rd and mem_wr are never 1 in the same cycle. No address other than the instruction's operand address is ever written.
- R8: An opcode outside the encodings above raises unsupported in its start cycle only. It starts no instruction and makes no memory access and no flag update.
- R9: A start pulse while busy is 1 is ignored. The running instruction keeps its address, timing and results.
- R10: Zero-page forms use address {00, op_lo}. The absolute forms use {op_hi, op_lo}. The address stays stable for the whole instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction start pulse (cycle 1) |
| opcode | input | 8 | Instruction opcode |
| op_lo | input | 8 | First operand byte (zero-page address or absolute low) |
| op_hi | input | 8 | Second operand byte (branch offset or absolute high) |
| pc | input | 16 | Address of the opcode byte |
| acc | input | 8 | Accumulator value, sampled at start |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_rd is 1 |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress (cycles 2 to last) |
| done | output | 1 | Final cycle of the instruction |
| z_we | output | 1 | Zero-flag update strobe |
| z_val | output | 1 | New zero-flag value |
| br_taken | output | 1 | Branch taken, in the done cycle |
| br_target | output | 16 | Branch target address |
| unsupported | output | 1 | Start with an unknown opcode |

## Verification
The assertions check these rules on every cycle:
- reads and writes never overlap;
- every write comes exactly two cycles after a read;
- flag updates and branch decisions appear only with done;
- a rejected opcode never raises busy;
- done is always followed by an idle cycle;
- the address holds steady while busy.

Other properties depend on data and can only be shown by the bench's scenarios:
- which bit is cleared or set for each opcode;
- the write-back values of the accumulator mask operations;
- the zero result;
- branch polarity;
- target wrap-around;
- the exact cycle counts of the zero-page and absolute forms.

The bench's reference model compares every strobe, address and data value in every cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [2:0] {
        BOP_NONE = 3'd0,
        BOP_CLRB = 3'd1,
        BOP_SETB = 3'd2,
        BOP_BRCL = 3'd3,
        BOP_BRST = 3'd4,
        BOP_MCLR = 3'd5,
        BOP_MSET = 3'd6
    } bop_e;

    localparam int OPC_W  = 8;
    localparam int BSEL_W = 3;
    localparam int CNT_W  = 3;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    output bop_e              kind,
    output logic [BSEL_W-1:0] bsel,
    output logic              is_abs,
    output logic [CNT_W-1:0]  last_cyc,
    output logic [CNT_W-1:0]  rd_cyc,
    output logic              valid
);
    localparam logic [CNT_W-1:0] ZP_LAST  = CNT_W'(5);
    localparam logic [CNT_W-1:0] ABS_LAST = CNT_W'(6);
    localparam logic [CNT_W-1:0] ZP_RD    = CNT_W'(3);
    localparam logic [CNT_W-1:0] ABS_RD   = CNT_W'(4);

    always_comb begin
        kind     = BOP_NONE;
        bsel     = opcode[6:4];
        is_abs   = 1'b0;
        valid    = 1'b1;
        unique case (opcode[3:0])
            4'h7: kind = opcode[7] ? BOP_SETB : BOP_CLRB;
            4'hF: kind = opcode[7] ? BOP_BRST : BOP_BRCL;
            4'h4, 4'hC: begin
                if (opcode[7:5] == 3'b000) begin
                    kind   = opcode[4] ? BOP_MCLR : BOP_MSET;
                    is_abs = opcode[3];
                end else begin
                    valid = 1'b0;
                end
            end
            default: valid = 1'b0;
        endcase
        last_cyc = is_abs ? ABS_LAST : ZP_LAST;
        rd_cyc   = is_abs ? ABS_RD : ZP_RD;
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bop_e              kind,
    input  logic [BSEL_W-1:0] bsel,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] acc_val,
    output logic [DATA_W-1:0] wdata,
    output logic              zero,
    output logic              hit
);
    logic [DATA_W-1:0] mask;
    logic              tested;

    always_comb begin
        mask   = DATA_W'(1) << bsel;
        tested = |(mem_val & mask);
        zero   = ((acc_val & mem_val) == '0);
        wdata  = mem_val;
        hit    = 1'b0;
        case (kind)
            BOP_CLRB: wdata = mem_val & ~mask;
            BOP_SETB: wdata = mem_val | mask;
            BOP_MCLR: wdata = mem_val & ~acc_val;
            BOP_MSET: wdata = mem_val | acc_val;
            BOP_BRCL: hit   = ~tested;
            BOP_BRST: hit   = tested;
            default:  wdata = mem_val;
        endcase
    end
endmodule

// File: rtl/bitop_exec_unit.sv
module bitop_exec_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              z_we,
    output logic              z_val,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic              unsupported
);
    localparam int EXT_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] INSN_LEN = ADDR_W'(3);
    localparam logic [CNT_W-1:0]  FIRST_BUSY = CNT_W'(2);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        bop_e               kind;
        logic [BSEL_W-1:0]  bsel;
        logic [CNT_W-1:0]   last_cyc;
        logic [CNT_W-1:0]   rd_cyc;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  acc;
        logic [DATA_W-1:0]  data;
        logic [ADDR_W-1:0]  tgt;
    } state_t;

    state_t st_d, st_q;

    bop_e              dec_kind;
    logic [BSEL_W-1:0] dec_bsel;
    logic              dec_abs;
    logic [CNT_W-1:0]  dec_last;
    logic [CNT_W-1:0]  dec_rd;
    logic              dec_valid;

    bitop_decode i_decode (
        .opcode   (opcode),
        .kind     (dec_kind),
        .bsel     (dec_bsel),
        .is_abs   (dec_abs),
        .last_cyc (dec_last),
        .rd_cyc   (dec_rd),
        .valid    (dec_valid)
    );

    logic [DATA_W-1:0] alu_wdata;
    logic              alu_zero;
    logic              alu_hit;

    bitop_alu #(.DATA_W(DATA_W)) i_alu (
        .kind    (st_q.kind),
        .bsel    (st_q.bsel),
        .mem_val (st_q.data),
        .acc_val (st_q.acc),
        .wdata   (alu_wdata),
        .zero    (alu_zero),
        .hit     (alu_hit)
    );

    logic [ADDR_W-1:0] zp_addr, abs_addr, offs_ext;
    logic              accept, rd_now, last_now, writes, sets_z, branches;

    always_comb begin
        zp_addr  = {{EXT_W{1'b0}}, op_lo};
        abs_addr = ADDR_W'({op_hi, op_lo});
        offs_ext = {{EXT_W{op_hi[DATA_W-1]}}, op_hi};
        accept   = start && !st_q.busy && dec_valid;

        st_d = st_q;
        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.cnt      = FIRST_BUSY;
            st_d.kind     = dec_kind;
            st_d.bsel     = dec_bsel;
            st_d.last_cyc = dec_last;
            st_d.rd_cyc   = dec_rd;
            st_d.addr     = dec_abs ? abs_addr : zp_addr;
            st_d.acc      = acc;
            st_d.tgt      = pc + INSN_LEN + offs_ext;
        end else if (st_q.busy) begin
            if (st_q.cnt == st_q.last_cyc) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (st_q.cnt == st_q.rd_cyc) begin
                st_d.data = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_now   = st_q.busy && (st_q.cnt == st_q.rd_cyc);
        last_now = st_q.busy && (st_q.cnt == st_q.last_cyc);
        writes   = (st_q.kind == BOP_CLRB) || (st_q.kind == BOP_SETB) ||
                   (st_q.kind == BOP_MCLR) || (st_q.kind == BOP_MSET);
        sets_z   = (st_q.kind == BOP_MCLR) || (st_q.kind == BOP_MSET);
        branches = (st_q.kind == BOP_BRCL) || (st_q.kind == BOP_BRST);
    end

    assign mem_addr    = st_q.addr;
    assign mem_rd      = rd_now;
    assign mem_wr      = last_now && writes;
    assign mem_wdata   = alu_wdata;
    assign busy        = st_q.busy;
    assign done        = last_now;
    assign z_we        = last_now && sets_z;
    assign z_val       = alu_zero;
    assign br_taken    = last_now && branches && alu_hit;
    assign br_target   = st_q.tgt;
    assign unsupported = start && !st_q.busy && !dec_valid;

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd, 2));

    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !unsupported) |=> busy);

    // R8
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |=> (!busy && !mem_rd && !mem_wr));

    // R5
    result_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (z_we || br_taken) |-> done);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

// File: tb/test_bitop_exec_unit.sv
module test_bitop_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, op_lo = '0, op_hi = '0, acc = '0;
    logic [15:0] pc = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, br_target;
    logic        mem_rd, mem_wr, busy, done, z_we, z_val, br_taken, unsupported;
    logic [7:0]  mem_wdata;

    always #4 clk = ~clk;

    bitop_exec_unit i_bitop_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_lo(op_lo), .op_hi(op_hi), .pc(pc), .acc(acc),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .z_we(z_we), .z_val(z_val), .br_taken(br_taken),
        .br_target(br_target), .unsupported(unsupported)
    );

    logic [7:0] dut_mem [0:4095];
    logic [7:0] ref_mem [0:4095];
    assign mem_rdata = dut_mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_wr) dut_mem[mem_addr[11:0]] <= mem_wdata;

    typedef struct packed {
        logic rd, wr; logic [15:0] addr; logic [7:0] wd;
        logic dn, zwe, z, brt; logic [15:0] tgt; logic uns;
    } exp_t;

    exp_t  q_exp [$];
    string q_tag [$];
    int    n_tests = 0, n_fail = 0, cyc = 0;
    bit    cmp_on = 0;

    always @(negedge clk) begin
        exp_t  e;
        string t;
        bit    ok;
        #2;
        cyc++;
        if (cmp_on) begin
            e = '0; t = "R7 idle";
            if (q_exp.size() > 0) begin e = q_exp.pop_front(); t = q_tag.pop_front(); end
            ok = (mem_rd == e.rd) && (mem_wr == e.wr) && (done == e.dn) &&
                 (z_we == e.zwe) && (br_taken == e.brt) && (unsupported == e.uns);
            if ((e.rd || e.wr) && mem_addr != e.addr) ok = 0;
            if (e.wr && mem_wdata != e.wd) ok = 0;
            if (e.zwe && z_val != e.z) ok = 0;
            if (e.brt && br_target != e.tgt) ok = 0;
            n_tests++;
            if (!ok) begin
                n_fail++;
                $display("FAIL %s cyc=%0d act rd%b wr%b a%h wd%h dn%b zwe%b z%b br%b t%h un%b exp rd%b wr%b a%h wd%h dn%b zwe%b z%b br%b t%h un%b",
                    t, cyc, mem_rd, mem_wr, mem_addr, mem_wdata, done, z_we, z_val, br_taken, br_target, unsupported,
                    e.rd, e.wr, e.addr, e.wd, e.dn, e.zwe, e.z, e.brt, e.tgt, e.uns);
            end
        end
    end

    // Behavioural reference: builds the per-cycle expectation list, then drives.
    task automatic issue(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [15:0] p, input logic [7:0] a, input string tag,
                         input bit intrude);
        int n = 1, rdc = 0;
        bit wr = 0, zwe = 0, brt = 0, uns = 0, z = 0;
        logic [15:0] ad = '0, tg = '0;
        logic [7:0]  v, nw = '0;
        int b = op[6:4];
        if (op[3:0] == 4'h7 || op[3:0] == 4'hF) begin
            ad = {8'h00, lo}; n = 5; rdc = 3; v = ref_mem[ad[11:0]];
            if (op[3:0] == 4'h7) begin
                wr = 1;
                nw = op[7] ? (v | (8'h01 << b)) : (v & ~(8'h01 << b));
            end else begin
                brt = (v[b] == op[7]);
                tg  = 16'(int'(p) + 3 + int'($signed(hi)));
            end
        end else if (op == 8'h04 || op == 8'h0C || op == 8'h14 || op == 8'h1C) begin
            ad  = op[3] ? {hi, lo} : {8'h00, lo};
            n   = op[3] ? 6 : 5; rdc = op[3] ? 4 : 3;
            v   = ref_mem[ad[11:0]];
            wr  = 1; zwe = 1; z = ((a & v) == 8'h00);
            nw  = op[4] ? (v & ~a) : (v | a);
        end else begin
            uns = 1;
        end
        if (wr) ref_mem[ad[11:0]] = nw;
        @(negedge clk);
        for (int k = 1; k <= n; k++) begin
            exp_t e = '0;
            e.uns = uns && (k == 1);
            e.rd  = (k == rdc); e.addr = ad;
            e.wr  = wr && (k == n); e.wd = nw;
            e.dn  = !uns && (k == n);
            e.zwe = zwe && (k == n); e.z = z;
            e.brt = brt && (k == n); e.tgt = tg;
            q_exp.push_back(e); q_tag.push_back(tag);
        end
        start = 1; opcode = op; op_lo = lo; op_hi = hi; pc = p; acc = a;
        for (int k = 2; k <= n; k++) begin
            @(negedge clk);
            start = 0;
            if (intrude && k == 3) begin   // R9: foreign start while busy
                start = 1; opcode = 8'h97; op_lo = 8'h55; op_hi = 8'hAA; acc = 8'hFF;
            end
        end
        @(negedge clk); #1 start = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            dut_mem[i] = 8'((i * 37) ^ (i >> 3));
            ref_mem[i] = dut_mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #2;
        n_tests++;
        if (mem_rd || mem_wr || done || z_we || br_taken || busy || unsupported) begin
            n_fail++;
            $display("FAIL R6 reset state act busy=%b done=%b rd=%b wr=%b exp all 0", busy, done, mem_rd, mem_wr);
        end
        cmp_on = 1;
        // R1 clear bit b of all-ones bytes
        for (int b = 0; b < 8; b++) begin
            ref_mem[16 + b] = 8'hFF; dut_mem[16 + b] = 8'hFF;
            issue(8'(b * 16 + 7), 8'(16 + b), 8'h00, 16'h0200, 8'h00, "R1 clear bit", 0);
        end
        // R2 set bit b of zero bytes
        for (int b = 0; b < 8; b++) begin
            ref_mem[32 + b] = 8'h00; dut_mem[32 + b] = 8'h00;
            issue(8'(8'h87 + b * 16), 8'(32 + b), 8'h00, 16'h0300, 8'h00, "R2 set bit", 0);
        end
        // R3 branches, both polarities, offset signs and address wrap
        ref_mem[8'h40] = 8'b1010_0101; dut_mem[8'h40] = 8'b1010_0101;
        for (int b = 0; b < 8; b++) begin
            issue(8'(b * 16 + 15), 8'h40, 8'h10, 16'h1000, 8'h00, "R3 branch on clear", 0);
            issue(8'(8'h8F + b * 16), 8'h40, 8'hF0, 16'h2000, 8'h00, "R3 branch on set", 0);
        end
        issue(8'h8F, 8'h40, 8'h7F, 16'hFFF0, 8'h00, "R3 target wrap", 0);
        issue(8'h2F, 8'h40, 8'h80, 16'h0010, 8'h00, "R3 target wrap back", 0);
        // R4 R5 R10 mask operations, zero and absolute
        ref_mem[8'h50] = 8'h0F; dut_mem[8'h50] = 8'h0F;
        issue(8'h04, 8'h50, 8'h00, 16'h0400, 8'hF0, "R4 R5 or-zp z=1", 0);
        issue(8'h04, 8'h50, 8'h00, 16'h0400, 8'h3C, "R4 R5 or-zp z=0", 0);
        issue(8'h14, 8'h50, 8'h00, 16'h0400, 8'h81, "R4 R5 andn-zp", 0);
        issue(8'h0C, 8'h34, 8'h0A, 16'h0400, 8'h66, "R4 R10 or-abs", 0);
        issue(8'h1C, 8'h34, 8'h0A, 16'h0400, 8'h0F, "R4 R10 andn-abs", 0);
        issue(8'h1C, 8'hFF, 8'h0F, 16'h0400, 8'h00, "R5 R10 andn-abs acc0", 0);
        // R8 unsupported opcodes
        issue(8'h00, 8'h50, 8'h00, 16'h0400, 8'hFF, "R8 unsupported 00", 0);
        issue(8'h24, 8'h50, 8'h00, 16'h0400, 8'hFF, "R8 unsupported 24", 0);
        issue(8'h1A, 8'h50, 8'h00, 16'h0400, 8'hFF, "R8 unsupported 1A", 0);
        issue(8'h8C, 8'h50, 8'h00, 16'h0400, 8'hFF, "R8 unsupported 8C", 0);
        // R9 start while busy ignored
        issue(8'h0C, 8'h20, 8'h03, 16'h0400, 8'h11, "R9 ignore start abs", 1);
        issue(8'h37, 8'h50, 8'h00, 16'h0400, 8'h00, "R9 ignore start zp", 1);
        issue(8'hFF, 8'h50, 8'h05, 16'h0100, 8'h00, "R9 ignore start branch", 1);
        repeat (4) @(negedge clk);
        #3;
        // R7 no stray writes: whole memory matches the reference
        n_tests++;
        begin
            int bad = -1;
            for (int i = 0; i < 4096; i++) if (bad < 0 && dut_mem[i] !== ref_mem[i]) bad = i;
            if (bad >= 0) begin
                n_fail++;
                $display("FAIL R7 memory at %0d act %h exp %h", bad, dut_mem[bad], ref_mem[bad]);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired act running exp finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule